// File: doc/BRIEF.md
# Configurable GPIO Port Controller

The block controls one general-purpose I/O port of `WIDTH` pins, eight by default, through a small register bus. Every pin has its own control bits: an output latch, a direction bit, a pull-up enable, an input-threshold select, and an open-drain select. Together these bits set the pad-control outputs the block drives: output enable, output value, pull-up enable, TTL-level select and analog select. Pad inputs go through a two-flop synchronizer before software can read them.

The low `ANA_PINS` pins can carry analog signals. A single count register makes pins 0 to N-1 analog as one contiguous block. An analog pin has its driver and pull-up switched off and reads back as 0. Pins above the analog-capable range stay digital for any count.

A timer-style peripheral output and an interrupt-style peripheral input belong to one alternate-function group. A one-bit redirection register places this group on one of two pin sets. Each pin merges the peripheral output with its latch by a wired-AND or a wired-OR, fixed by parameter. The latch must hold the neutral value for the peripheral signal to reach the pad.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, DIR, PULL, TTL, ODR, REDIR and the latch are 0 and the analog count is `ANA_PINS`. So pad_oe_o=0, pad_pu_o=0, pad_ttl_o=0, and pad_ana_o has bits 0..ANA_PINS-1 set.
- R2: A write to address 0 (DATA) loads the latch. pad_out_o follows it on the next cycle. A DATA read of a pin in output mode returns its latch bit.
- R3: DIR (address 1) bit=1 makes the pin an output. With open-drain off, pad_oe_o of a digital pin equals its DIR bit.
- R4: PULL (address 2) sets pad_pu_o only for digital pins whose DIR bit is 0. In output mode the pull-up is forced off.
- R5: When a pin's ODR (address 4) bit is 1, it is driven only while its output value is 0. pad_oe_o is 0 when the value is 1.
- R6: TTL (address 3) bits appear unchanged on pad_ttl_o.
- R7: The analog count ACNT (address 5) makes pins 0..N-1 analog. An analog pin has pad_oe_o=0 and pad_pu_o=0 whatever DIR and PULL say, and it reads 0 at DATA.
- R8: Pins at index ANA_PINS or above never become analog, even when the count is larger than ANA_PINS.
- R9: A digital input pin reads at DATA the value pad_in_i had two clock edges earlier. A read after only one edge still returns the old value.
- R10: REDIR (address 6, bit 0) = 0 puts the peripheral output on pin TMR_PIN_A and takes irq_o from pin IRQ_PIN_A. REDIR = 1 uses pins TMR_PIN_B and IRQ_PIN_B. A pin outside the selected set gets the neutral value.
- R11: Pins whose AND_MASK bit is 1 output latch AND peripheral. All other pins output latch OR peripheral.
- R12: Reads of DIR, PULL, TTL, ODR, ACNT and REDIR return the written values. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | WIDTH | Write data |
| reg_rdata_o | output | WIDTH | Combinational read data |
| per_out_i | input | 1 | Peripheral alternate-function output |
| irq_o | output | 1 | Synchronized pin value routed to the peripheral input |
| pad_in_i | input | WIDTH | Raw pad input levels |
| pad_oe_o | output | WIDTH | Pad output enable |
| pad_out_o | output | WIDTH | Pad output value |
| pad_pu_o | output | WIDTH | Pad pull-up enable |
| pad_ttl_o | output | WIDTH | TTL threshold select |
| pad_ana_o | output | WIDTH | Analog mode select |

## Verification
The pad-control function is tried with several patterns of latch and direction values:
- A mixed direction pattern with every pull-up enabled shows that the pull-up is gated by input mode.
- An alternating latch pattern with open-drain enabled shows that the output enable is the inverse of the output value.
- Analog counts of 0, 2 and a value above the capable range show that the analog range is contiguous and clipped at `ANA_PINS`.

The alternate-function tests cover both redirection settings. Each setting is run with neutral and non-neutral latch values, so a wired-AND pin and a wired-OR pin can each be told apart from a plain latch pin.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    REG_DATA  = 3'd0,
    REG_DIR   = 3'd1,
    REG_PULL  = 3'd2,
    REG_TTL   = 3'd3,
    REG_ODR   = 3'd4,
    REG_ACNT  = 3'd5,
    REG_REDIR = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end
  assign q_o = sync_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int ANA_PINS = 4,
  parameter int CNT_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  latch_o,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  pull_o,
  output logic [WIDTH-1:0]  ttl_o,
  output logic [WIDTH-1:0]  odr_o,
  output logic [CNT_W-1:0]  acnt_o,
  output logic              redir_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o <= '0;
      dir_o   <= '0;
      pull_o  <= '0;
      ttl_o   <= '0;
      odr_o   <= '0;
      acnt_o  <= CNT_W'(ANA_PINS);
      redir_o <= 1'b0;
    end else if (we_i) begin
      case (reg_addr_e'(addr_i))
        REG_DATA:  latch_o <= wdata_i;
        REG_DIR:   dir_o   <= wdata_i;
        REG_PULL:  pull_o  <= wdata_i;
        REG_TTL:   ttl_o   <= wdata_i;
        REG_ODR:   odr_o   <= wdata_i;
        REG_ACNT:  acnt_o  <= wdata_i[CNT_W-1:0];
        REG_REDIR: redir_o <= wdata_i[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_alt_route.sv
module gpio_alt_route #(
  parameter int WIDTH     = 8,
  parameter int TMR_PIN_A = 1,
  parameter int TMR_PIN_B = 6,
  parameter int IRQ_PIN_A = 2,
  parameter int IRQ_PIN_B = 7
) (
  input  logic             redir_i,
  input  logic [WIDTH-1:0] sin_i,
  output logic [WIDTH-1:0] alt_sel_o,
  output logic             irq_o
);
  localparam logic [WIDTH-1:0] SEL_A = WIDTH'(1) << TMR_PIN_A;
  localparam logic [WIDTH-1:0] SEL_B = WIDTH'(1) << TMR_PIN_B;
  assign alt_sel_o = redir_i ? SEL_B : SEL_A;
  assign irq_o     = redir_i ? sin_i[IRQ_PIN_B] : sin_i[IRQ_PIN_A];
endmodule

// File: rtl/gpio_pad_logic.sv
module gpio_pad_logic #(
  parameter int               WIDTH    = 8,
  parameter int               ANA_PINS = 4,
  parameter int               CNT_W    = 4,
  parameter logic [WIDTH-1:0] AND_MASK = 8'h0F
) (
  input  logic [WIDTH-1:0] latch_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] pull_i,
  input  logic [WIDTH-1:0] odr_i,
  input  logic [CNT_W-1:0] acnt_i,
  input  logic [WIDTH-1:0] alt_sel_i,
  input  logic             per_out_i,
  input  logic [WIDTH-1:0] sin_i,
  output logic [WIDTH-1:0] oe_o,
  output logic [WIDTH-1:0] out_o,
  output logic [WIDTH-1:0] pu_o,
  output logic [WIDTH-1:0] ana_o,
  output logic [WIDTH-1:0] rd_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    localparam bit CAP     = (i < ANA_PINS);
    localparam bit AND_PIN = AND_MASK[i];
    logic ana, alt, val;
    assign ana = CAP && (CNT_W'(i) < acnt_i);
    // neutral value lets the latch pass unchanged
    assign alt = alt_sel_i[i] ? per_out_i : AND_PIN;
    assign val = AND_PIN ? (latch_i[i] & alt) : (latch_i[i] | alt);
    assign oe_o[i]  = !ana && dir_i[i] && (!odr_i[i] || !val);
    assign out_o[i] = val;
    assign pu_o[i]  = !ana && !dir_i[i] && pull_i[i];
    assign ana_o[i] = ana;
    assign rd_o[i]  = ana ? 1'b0 : (dir_i[i] ? latch_i[i] : sin_i[i]);
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter int               ANA_PINS  = 4,
  parameter logic [WIDTH-1:0] AND_MASK  = 8'h0F,
  parameter int               TMR_PIN_A = 1,
  parameter int               TMR_PIN_B = 6,
  parameter int               IRQ_PIN_A = 2,
  parameter int               IRQ_PIN_B = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [WIDTH-1:0] reg_wdata_i,
  output logic [WIDTH-1:0] reg_rdata_o,
  input  logic             per_out_i,
  output logic             irq_o,
  input  logic [WIDTH-1:0] pad_in_i,
  output logic [WIDTH-1:0] pad_oe_o,
  output logic [WIDTH-1:0] pad_out_o,
  output logic [WIDTH-1:0] pad_pu_o,
  output logic [WIDTH-1:0] pad_ttl_o,
  output logic [WIDTH-1:0] pad_ana_o
);
  localparam int CNT_W = $clog2(WIDTH + 1);

  logic [WIDTH-1:0] latch_q, dir_q, pull_q, ttl_q, odr_q;
  logic [CNT_W-1:0] acnt_q;
  logic             redir_q;
  logic [WIDTH-1:0] sin, alt_sel, rd_data;

  gpio_regs #(.WIDTH(WIDTH), .ANA_PINS(ANA_PINS), .CNT_W(CNT_W)) i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .latch_o(latch_q), .dir_o(dir_q), .pull_o(pull_q), .ttl_o(ttl_q),
    .odr_o(odr_q), .acnt_o(acnt_q), .redir_o(redir_q)
  );

  gpio_sync #(.WIDTH(WIDTH)) i_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i), .q_o(sin)
  );

  gpio_alt_route #(
    .WIDTH(WIDTH), .TMR_PIN_A(TMR_PIN_A), .TMR_PIN_B(TMR_PIN_B),
    .IRQ_PIN_A(IRQ_PIN_A), .IRQ_PIN_B(IRQ_PIN_B)
  ) i_alt (
    .redir_i(redir_q), .sin_i(sin), .alt_sel_o(alt_sel), .irq_o(irq_o)
  );

  gpio_pad_logic #(
    .WIDTH(WIDTH), .ANA_PINS(ANA_PINS), .CNT_W(CNT_W), .AND_MASK(AND_MASK)
  ) i_pad (
    .latch_i(latch_q), .dir_i(dir_q), .pull_i(pull_q), .odr_i(odr_q),
    .acnt_i(acnt_q), .alt_sel_i(alt_sel), .per_out_i(per_out_i), .sin_i(sin),
    .oe_o(pad_oe_o), .out_o(pad_out_o), .pu_o(pad_pu_o), .ana_o(pad_ana_o),
    .rd_o(rd_data)
  );

  assign pad_ttl_o = ttl_q;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_e'(reg_addr_i))
      REG_DATA:  reg_rdata_o = rd_data;
      REG_DIR:   reg_rdata_o = dir_q;
      REG_PULL:  reg_rdata_o = pull_q;
      REG_TTL:   reg_rdata_o = ttl_q;
      REG_ODR:   reg_rdata_o = odr_q;
      REG_ACNT:  reg_rdata_o = WIDTH'(acnt_q);
      REG_REDIR: reg_rdata_o = WIDTH'(redir_q);
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int WIDTH    = 8,
  parameter int ANA_PINS = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] pad_oe_o,
  input logic [WIDTH-1:0] pad_out_o,
  input logic [WIDTH-1:0] pad_pu_o,
  input logic [WIDTH-1:0] pad_ana_o,
  input logic [WIDTH-1:0] odr_q
);
  localparam logic [WIDTH-1:0] CAP_MASK = (WIDTH'(1) << ANA_PINS) - WIDTH'(1);

  AST_PU_NOT_WITH_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_pu_o & pad_oe_o) == '0); // R4

  AST_OD_DRIVES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (odr_q & pad_oe_o & pad_out_o) == '0); // R5

  AST_ANA_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_ana_o & (pad_oe_o | pad_pu_o)) == '0); // R7

  AST_ANA_CONTIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_ana_o + WIDTH'(1)) & pad_ana_o) == '0); // R7

  AST_ANA_CAPABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_ana_o & ~CAP_MASK) == '0); // R8
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.WIDTH(WIDTH), .ANA_PINS(ANA_PINS)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pad_oe_o(pad_oe_o), .pad_out_o(pad_out_o),
  .pad_pu_o(pad_pu_o), .pad_ana_o(pad_ana_o), .odr_q(odr_q)
);

// File: tb/test_gpio_port_ctrl.sv
`timescale 1ns/1ps
module test_gpio_port_ctrl;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0, reg_rdata_o;
  logic       per_out_i = 1'b1, irq_o;
  logic [7:0] pad_in_i = '0, pad_oe_o, pad_out_o, pad_pu_o, pad_ttl_o, pad_ana_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  gpio_port_ctrl i_gpio_port_ctrl (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 oe", pad_oe_o, 8'h00);
    chk("R1 pu", pad_pu_o, 8'h00);
    chk("R1 ttl", pad_ttl_o, 8'h00);
    chk("R1 ana", pad_ana_o, 8'h0F);
    rd(3'd5, d); chk("R1 acnt", d, 8'd4);
    rd(3'd1, d); chk("R1 dir", d, 8'h00);
  endtask

  task automatic t_latch_dir();
    logic [7:0] d;
    wr(3'd5, 8'd0);
    wr(3'd1, 8'hFF);
    wr(3'd0, 8'hA5);
    chk("R2 out", pad_out_o, 8'hA5);
    chk("R3 oe", pad_oe_o, 8'hFF);
    rd(3'd0, d); chk("R2 readback", d, 8'hA5);
  endtask

  task automatic t_pull();
    wr(3'd1, 8'h0F);
    wr(3'd2, 8'hFF);
    chk("R4 pu", pad_pu_o, 8'hF0);
    chk("R3 oe mixed", pad_oe_o, 8'h0F);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_odrain();
    wr(3'd1, 8'hFF);
    wr(3'd4, 8'hFF);
    chk("R5 oe", pad_oe_o, 8'h5A);
    chk("R5 out", pad_out_o, 8'hA5);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_ttl();
    wr(3'd3, 8'h3C);
    chk("R6 ttl", pad_ttl_o, 8'h3C);
  endtask

  task automatic t_analog();
    logic [7:0] d;
    wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd0, 8'hFF);
    wr(3'd5, 8'd2);
    chk("R7 ana", pad_ana_o, 8'h03);
    chk("R7 oe", pad_oe_o, 8'hFC);
    rd(3'd0, d); chk("R7 read", d, 8'hFC);
    wr(3'd1, 8'h00);
    chk("R7 pu", pad_pu_o, 8'hFC);
    wr(3'd5, 8'd8);
    chk("R8 ana", pad_ana_o, 8'h0F);
    wr(3'd5, 8'd0);
    chk("R7 none", pad_ana_o, 8'h00);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_sync();
    logic [7:0] d;
    wr(3'd1, 8'h00);
    @(negedge clk_i) pad_in_i = 8'h69;
    @(negedge clk_i); rd(3'd0, d); chk("R9 one edge", d, 8'h00);
    @(negedge clk_i); rd(3'd0, d); chk("R9 two edges", d, 8'h69);
  endtask

  task automatic t_redirect();
    wr(3'd1, 8'hFF);
    wr(3'd0, 8'h0F); // AND pins at 1, OR pins at 0: neutral
    per_out_i = 1'b0; #1;
    chk("R10 A low", pad_out_o, 8'h0D);
    per_out_i = 1'b1; #1;
    chk("R10 A high", pad_out_o, 8'h0F);
    wr(3'd6, 8'h01);
    chk("R10 B high", pad_out_o, 8'h4F);
    per_out_i = 1'b0; #1;
    chk("R10 B low", pad_out_o, 8'h0F);
    wr(3'd0, 8'h4F);
    chk("R11 OR latch", pad_out_o, 8'h4F);
    wr(3'd6, 8'h00); wr(3'd0, 8'h0D); per_out_i = 1'b1; #1;
    chk("R11 AND latch", pad_out_o, 8'h0D);
    wr(3'd1, 8'h00);
    @(negedge clk_i) pad_in_i = 8'h04;
    repeat (3) @(negedge clk_i);
    chk("R10 irq A", {7'd0, irq_o}, 8'h01);
    wr(3'd6, 8'h01);
    chk("R10 irq B", {7'd0, irq_o}, 8'h00);
    @(negedge clk_i) pad_in_i = 8'h80;
    repeat (3) @(negedge clk_i);
    chk("R10 irq B high", {7'd0, irq_o}, 8'h01);
  endtask

  task automatic t_readback();
    logic [7:0] d;
    wr(3'd4, 8'h81); rd(3'd4, d); chk("R12 odr", d, 8'h81);
    rd(3'd6, d); chk("R12 redir", d, 8'h01);
    wr(3'd2, 8'h5A); rd(3'd2, d); chk("R12 pull", d, 8'h5A);
    rd(3'd3, d); chk("R12 ttl", d, 8'h3C);
    rd(3'd7, d); chk("R12 unused", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_latch_dir();
    t_pull();
    t_odrain();
    t_ttl();
    t_analog();
    t_sync();
    t_redirect();
    t_readback();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule